// File: doc/BRIEF.md
# Universal Bidirectional Bus Register Transceiver

This block sits between two 18-bit ports, A and B, and moves data in both directions through two independent and identical paths. Each path has one storage element. When the path's latch enable is high the element is transparent and its output follows its input with no clock involved. When the latch enable is low the element holds its value, and it loads new data only on a rising edge of that path's capture strobe while the active-low strobe enable is asserted.

The capture strobes are ordinary inputs. They are sampled by the block's system clock, and a rising edge counts when a strobe is seen high after it was seen low on the previous clock edge. Outputs are never tri-stated inside the block. Each port has a data output and a drive flag taken from that direction's active-low output enable. A contention flag goes high whenever both directions would drive at the same time. The reset input is asynchronous and active low. Its release passes through a two-stage synchronizer, and reset clears both storage elements.

Top module: `xcv_bus_transceiver`

## Requirements
- R1: While reset is asserted, and after it is released, both storage elements hold zero. With the latch enables low, `a_out` and `b_out` read 0 until the first capture.
- R2: With `ab_le` high, `b_out` equals `a_in` in the same cycle, with no clock edge needed. The same holds for `ba_le`, `a_out` and `b_in`.
- R3: With the latch enable low and the strobe not rising, the stored value and the port output do not change, whatever the data input does.
- R4: With the latch enable low and the enable `ab_stb_en_n` = 0, a clock edge at which `ab_stb` is 1 and was 0 at the previous clock edge loads `a_in` into storage. The value appears on `b_out` after that edge.
- R5: With `ab_stb_en_n` = 1, a rising strobe leaves the stored value unchanged. The same holds for `ba_stb_en_n`.
- R6: When the latch enable falls, the output keeps the input value sampled at the last clock edge while the enable was high, until the next enabled capture.
- R7: `b_drive` = 1 exactly when `ab_oe_n` = 0, and `a_drive` = 1 exactly when `ba_oe_n` = 0. The data outputs do not depend on the output enables.
- R8: The B-to-A path (`b_in` to `a_out`, through `ba_le`, `ba_stb`, `ba_stb_en_n` and `ba_oe_n`) behaves exactly like the A-to-B path.
- R9: `bus_clash` = 1 exactly when `a_drive` and `b_drive` are both 1.
- R10: A falling strobe edge, or a strobe held high, loads nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| a_in | input | 18 | Data arriving on port A |
| a_out | output | 18 | Data presented to port A by the B-to-A path |
| a_drive | output | 1 | Port A drive flag |
| b_in | input | 18 | Data arriving on port B |
| b_out | output | 18 | Data presented to port B by the A-to-B path |
| b_drive | output | 1 | Port B drive flag |
| ab_le | input | 1 | A-to-B latch enable: 1 makes the path transparent |
| ab_stb | input | 1 | A-to-B capture strobe |
| ab_stb_en_n | input | 1 | A-to-B strobe enable, active low |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_stb | input | 1 | B-to-A capture strobe |
| ba_stb_en_n | input | 1 | B-to-A strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| bus_clash | output | 1 | High when both ports are driven at once |

## Verification
Transparent data, the drive flags and the contention flag are due in the same cycle as their inputs. The bench drives on the falling clock edge and checks 5 ns later, before any rising edge. A strobe capture, and the value kept when a latch enable falls, are due one rising edge after the input is applied. So each vector states the output expected before the next rising edge, computed from the storage state that the earlier rows left behind. Reset clears storage at once without a clock, so the mid-run reset test checks the outputs while reset is still low, and again after release.

// File: rtl/xcv_pkg.sv
package xcv_pkg;
  localparam int XCV_W = 18;
  localparam int XCV_SYNC_STAGES = 2;
  localparam int XCV_NDIR = 2;
  localparam int DIR_AB = 0;
  localparam int DIR_BA = 1;
endpackage

// File: rtl/xcv_rst_sync.sv
module xcv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/xcv_edge_det.sv
module xcv_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb prev_d = sig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = sig & ~prev_q;
endmodule

// File: rtl/xcv_dir_path.sv
module xcv_dir_path #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         le,
  input  logic         stb,
  input  logic         stb_en_n,
  output logic [W-1:0] dout
);
  logic         stb_rise;
  logic         load;
  logic [W-1:0] st_q;
  logic [W-1:0] st_d;

  xcv_edge_det u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .sig  (stb),
    .rise (stb_rise)
  );

  // transparent mode refreshes storage every cycle so a falling enable keeps the last value
  always_comb begin
    load = le | (stb_rise & ~stb_en_n);
    st_d = st_q;
    if (load) st_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign dout = le ? din : st_q;
endmodule

// File: rtl/xcv_bus_transceiver.sv
module xcv_bus_transceiver #(
  parameter int W = xcv_pkg::XCV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_drive,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  input  logic         ab_le,
  input  logic         ab_stb,
  input  logic         ab_stb_en_n,
  input  logic         ab_oe_n,
  input  logic         ba_le,
  input  logic         ba_stb,
  input  logic         ba_stb_en_n,
  input  logic         ba_oe_n,
  output logic         bus_clash
);
  import xcv_pkg::*;

  logic         rst_int_n;
  logic [W-1:0] p_din  [XCV_NDIR];
  logic [W-1:0] p_dout [XCV_NDIR];
  logic         p_le   [XCV_NDIR];
  logic         p_stb  [XCV_NDIR];
  logic         p_en_n [XCV_NDIR];

  xcv_rst_sync #(.STAGES(XCV_SYNC_STAGES)) u_rst (
    .clk   (clk),
    .arst_n(rst_n),
    .srst_n(rst_int_n)
  );

  assign p_din[DIR_AB]  = a_in;
  assign p_le[DIR_AB]   = ab_le;
  assign p_stb[DIR_AB]  = ab_stb;
  assign p_en_n[DIR_AB] = ab_stb_en_n;
  assign p_din[DIR_BA]  = b_in;
  assign p_le[DIR_BA]   = ba_le;
  assign p_stb[DIR_BA]  = ba_stb;
  assign p_en_n[DIR_BA] = ba_stb_en_n;

  generate
    for (genvar g = 0; g < XCV_NDIR; g++) begin : g_dir
      xcv_dir_path #(.W(W)) u_path (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .din     (p_din[g]),
        .le      (p_le[g]),
        .stb     (p_stb[g]),
        .stb_en_n(p_en_n[g]),
        .dout    (p_dout[g])
      );
    end
  endgenerate

  assign b_out     = p_dout[DIR_AB];
  assign a_out     = p_dout[DIR_BA];
  assign b_drive   = ~ab_oe_n;
  assign a_drive   = ~ba_oe_n;
  assign bus_clash = a_drive & b_drive;
endmodule

// File: rtl/xcv_bus_transceiver_chk.sv
module xcv_bus_transceiver_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic         ab_le,
  input logic         ab_stb,
  input logic         ab_stb_en_n,
  input logic         ba_le,
  input logic         ba_stb,
  input logic         ba_stb_en_n
);
  // R3: latch enable low and strobe low in the previous cycle -> no change
  p_hold_ab_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && $past(!ab_le) && $past(!ab_stb) && $past(rst_n)) |-> $stable(b_out));

  // R5: strobe enable deasserted -> no capture
  p_gate_ab_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && $past(!ab_le && ab_stb_en_n) && $past(rst_n)) |-> $stable(b_out));

  // R4: enabled rising strobe loads the input
  p_capture_ab_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && $past(!ab_le && !ab_stb_en_n && ab_stb) && !$past(ab_stb, 2)
     && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (b_out == $past(a_in)));

  // R6: falling latch enable keeps the last transparent value
  p_keep_ab_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && $past(ab_le) && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3))
    |-> (b_out == $past(a_in)));

  // R8: reverse path captures the same way
  p_capture_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && $past(!ba_le && !ba_stb_en_n && ba_stb) && !$past(ba_stb, 2)
     && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3)) |-> (a_out == $past(b_in)));

  // R8: reverse path holds the same way
  p_hold_ba_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && $past(!ba_le) && $past(!ba_stb || ba_stb_en_n) && $past(rst_n)) |-> $stable(a_out));
endmodule

bind xcv_bus_transceiver xcv_bus_transceiver_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .a_in       (a_in),
  .a_out      (a_out),
  .b_in       (b_in),
  .b_out      (b_out),
  .ab_le      (ab_le),
  .ab_stb     (ab_stb),
  .ab_stb_en_n(ab_stb_en_n),
  .ba_le      (ba_le),
  .ba_stb     (ba_stb),
  .ba_stb_en_n(ba_stb_en_n)
);

// File: tb/xcv_bus_transceiver_tb_top.sv
module xcv_bus_transceiver_tb_top;
  localparam int W = 18;
  localparam int NV = 12;

  typedef struct packed {
    logic         le_ab;
    logic         en_ab_n;
    logic         stb_ab;
    logic [W-1:0] a;
    logic         le_ba;
    logic         en_ba_n;
    logic         stb_ba;
    logic [W-1:0] b;
    logic         oe_ab_n;
    logic         oe_ba_n;
    logic [W-1:0] xb;
    logic [W-1:0] xa;
    logic         xbd;
    logic         xad;
    logic         xcl;
  } vec_t;

  // expected values are those seen before the rising edge that follows each row
  localparam vec_t VEC [NV] = '{
    '{0,0,0,18'h11111, 0,0,0,18'h22222, 0,1, 18'h00000,18'h00000, 1,0,0}, // R1 zero after reset
    '{0,0,1,18'h11111, 0,0,0,18'h22222, 0,1, 18'h00000,18'h00000, 1,0,0}, // R4 strobe rises here
    '{0,0,1,18'h33333, 0,0,0,18'h22222, 0,1, 18'h11111,18'h00000, 1,0,0}, // R4 loaded; R10 held high
    '{0,0,0,18'h33333, 0,0,0,18'h22222, 0,1, 18'h11111,18'h00000, 1,0,0}, // R10 falling edge, R3
    '{0,0,0,18'h33333, 0,0,1,18'h2A2A2, 0,1, 18'h11111,18'h00000, 1,0,0}, // R8 reverse strobe rises
    '{0,1,1,18'h04444, 0,0,1,18'h05555, 0,1, 18'h11111,18'h2A2A2, 1,0,0}, // R8 loaded; R5 gated rise
    '{0,1,0,18'h04444, 0,0,0,18'h05555, 1,0, 18'h11111,18'h2A2A2, 0,1,0}, // R5 no load; R7 flags
    '{1,0,0,18'h0ABCD, 0,0,0,18'h05555, 1,0, 18'h0ABCD,18'h2A2A2, 0,1,0}, // R2 transparent
    '{1,0,0,18'h12345, 0,0,0,18'h05555, 1,0, 18'h12345,18'h2A2A2, 0,1,0}, // R2 follows input
    '{0,0,0,18'h3FFFF, 0,0,0,18'h05555, 1,0, 18'h12345,18'h2A2A2, 0,1,0}, // R6 keeps last value
    '{0,0,0,18'h3FFFF, 1,0,0,18'h00F0F, 0,0, 18'h12345,18'h00F0F, 1,1,1}, // R9 clash; R2 reverse
    '{0,0,0,18'h3FFFF, 0,0,0,18'h3C3C3, 1,1, 18'h12345,18'h00F0F, 0,0,0}  // R6 reverse, R7 off
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         a_drive, b_drive, bus_clash;
  logic         ab_le, ab_stb, ab_stb_en_n, ab_oe_n;
  logic         ba_le, ba_stb, ba_stb_en_n, ba_oe_n;

  int total;
  int bad;

  xcv_bus_transceiver #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .ab_le(ab_le), .ab_stb(ab_stb), .ab_stb_en_n(ab_stb_en_n), .ab_oe_n(ab_oe_n),
    .ba_le(ba_le), .ba_stb(ba_stb), .ba_stb_en_n(ba_stb_en_n), .ba_oe_n(ba_oe_n),
    .bus_clash(bus_clash)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_all();
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    ab_le = 0; ab_stb = 0; ab_stb_en_n = 0; ab_oe_n = 1;
    ba_le = 0; ba_stb = 0; ba_stb_en_n = 0; ba_oe_n = 1;
    repeat (3) @(negedge clk);
    #5;
    check("R1 b_out in reset", b_out, '0);
    check("R1 a_out in reset", a_out, '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    check("R1 b_out after release", b_out, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ab_le = VEC[i].le_ab; ab_stb_en_n = VEC[i].en_ab_n; ab_stb = VEC[i].stb_ab; a_in = VEC[i].a;
      ba_le = VEC[i].le_ba; ba_stb_en_n = VEC[i].en_ba_n; ba_stb = VEC[i].stb_ba; b_in = VEC[i].b;
      ab_oe_n = VEC[i].oe_ab_n; ba_oe_n = VEC[i].oe_ba_n;
      #5;
      check($sformatf("row %0d b_out R2/R3/R4/R5/R6", i), b_out, VEC[i].xb);
      check($sformatf("row %0d a_out R8", i), a_out, VEC[i].xa);
      check($sformatf("row %0d b_drive R7", i), W'(b_drive), W'(VEC[i].xbd));
      check($sformatf("row %0d a_drive R7", i), W'(a_drive), W'(VEC[i].xad));
      check($sformatf("row %0d bus_clash R9", i), W'(bus_clash), W'(VEC[i].xcl));
    end

    // R5 on the reverse path: gated rising strobe
    @(negedge clk);
    ba_stb_en_n = 1; ba_stb = 1; b_in = 18'h11111;
    @(negedge clk);
    #5 check("R5 reverse gated", a_out, 18'h00F0F);
    @(negedge clk);
    ba_stb = 0; ba_stb_en_n = 0;
    // R4/R8 reverse enabled capture
    @(negedge clk);
    ba_stb = 1; b_in = 18'h1ABCD;
    @(negedge clk);
    #5 check("R8 reverse capture", a_out, 18'h1ABCD);
    ba_stb = 0;
    // R3: data change with everything idle
    b_in = 18'h2FFFF; a_in = 18'h00001;
    @(negedge clk);
    #5 check("R3 reverse hold", a_out, 18'h1ABCD);
    check("R3 forward hold", b_out, 18'h12345);
    // R7 data independent of output enables
    ab_oe_n = 1; ba_oe_n = 1;
    #1 check("R7 data with oe off", b_out, 18'h12345);

    // R1 mid-run reset clears at once
    @(negedge clk);
    rst_n = 0;
    #5;
    check("R1 async clear b_out", b_out, '0);
    check("R1 async clear a_out", a_out, '0);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #5 check("R1 zero after release", b_out, '0);
  endtask

  initial begin
    total = 0;
    bad = 0;
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule